// File: doc/BRIEF.md
# Parallel Slave Host Port

This block is the slave side of a byte-wide parallel host port, running on a local clock. An external master controls three pins: an active-low chip select, a read/write level (1 means the master reads and the slave drives), and a register-select line (0 selects the data register, 1 selects the control/handshake register). The 8-bit data bus is split into an input, an output and an output enable, for a pad cell outside the block. All three control pins, and the data input, pass through two-flop synchronisers. The transfer logic works only on the synchronised copies.

There are two ways to frame a transfer. In the first, chip select frames it: the read/write level when chip select falls sets the direction. In the second, chip select stays low and each low-high-low pulse on read/write frames one slave-drive transfer. This second form exists for masters that have separate read and write strobes but no chip select. The port also keeps a write-ownership token that passes back and forth between master and slave. A master control write with bit 0 set hands the token to the slave. The slave returns it with a `pass_token` pulse.

On the slave side there are two interfaces. Bytes from the master leave on a receive stream. It has no back-pressure, because a host strobe cannot be stalled: each `rx_valid` pulse lasts one cycle and must be taken in that cycle. Bytes for the master enter on a transmit stream. A one-byte holding register sits behind this stream: `tx_data` is loaded when `tx_valid && tx_ready`, and `tx_ready` stays low while the holding register is full.

Top module: `hpb_port`

## Requirements
- R1: After reset, the port is in this state: `host_d_oe` 0, `rx_valid` 0, `token_at_slave` 0, `bus_error` 0, `tx_ready` 1.
- R2: A master write is a cycle that opens with read/write 0 and whose synchronised chip select stays low for at least `MIN_LOW_CYC` clocks (default 5). Such a write yields exactly one `rx_valid` pulse after chip select rises. The pulse carries the byte that was on the bus while chip select was low, and `rx_sel` equals the register-select level.
- R3: A master write whose chip select is low for fewer than `MIN_LOW_CYC` clocks is dropped. It yields no `rx_valid` pulse and does not change the token.
- R4: When chip select falls with read/write 1, the slave starts driving. `host_d_oe` rises no later than 4 clocks after the synchronised fall and falls no later than 4 clocks after the synchronised rise. That is at most 6 clocks from the pin change. For register-select 0 the slave drives the holding byte.
- R5: A read of the control register follows the same timing as a data read. It drives the status byte {6'b0, holding-full at bit 1, token-at-slave at bit 0} and consumes nothing.
- R6: Suppose chip select falls with read/write 0 and register-select 0, and stays low. Each rise of read/write then starts a slave-drive transfer and each fall of read/write ends it, with the R4 latencies. There may be several such pulses in one chip-select window. A window that contained such a pulse produces no `rx_valid` when chip select rises.
- R7: Suppose read/write rises inside a chip-select window that opened as a write to the control register. Then `bus_error` sets, `host_d_oe` stays 0 for the rest of the window, and no byte is received. `bus_error` clears when the next host cycle starts.
- R8: A received control byte with bit 0 set gives the token to the slave. A control byte with bit 0 clear leaves the token unchanged. `pass_token` returns a token that the slave holds. If a token-giving write completes in the same cycle as a `pass_token`, the token ends at the slave.
- R9: `tx_ready` is high only when the holding register is empty and no data-register drive is in progress. Completing a data-register drive empties the holding register. A data drive from an empty holding register puts 0x00 on the bus.
- R10: `rx_valid` never stays high for two cycles in a row. Control writes also appear on the receive stream, with `rx_sel` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rw | input | 1 | Host direction: 1 = master reads, 0 = master writes |
| host_reg_sel | input | 1 | 0 selects the data register, 1 the control register |
| host_d_in | input | 8 | Data bus as seen from the pad |
| host_d_out | output | 8 | Byte the slave drives |
| host_d_oe | output | 1 | Pad output enable |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_sel | output | 1 | Register select of the received byte |
| rx_data | output | 8 | Received byte |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Holding register can take a byte |
| pass_token | input | 1 | Slave returns the write token |
| token_at_slave | output | 1 | Write token is held by the slave |
| bus_error | output | 1 | Drive request arrived during a control-write window |

## Verification
Two functions can land on the same clock edge: a completed control write that hands the token to the slave, and the slave's own `pass_token`. The bench provokes this by raising `pass_token` exactly in the cycle in which the synchronised chip-select rise completes a control write of 0x01 while the slave already holds the token. It then checks that the token remains at the slave and that `rx_valid` rises on that same edge. A second overlap comes from a data-register drive ending while the holding register is idle. For this one the bench checks that `tx_ready` stays low during the drive and returns high only afterwards.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_DRIVE_CS,
    ST_PULSE_WAIT,
    ST_DRIVE_RW,
    ST_FAULT
  } cyc_state_t;

  function automatic logic [BYTE_W-1:0] status_byte(input logic full, input logic tok);
    return {{(BYTE_W-2){1'b0}}, full, tok};
  endfunction

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  generate
    if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= d;
      end
      assign q = r_q;
    end else begin : g_chain
      localparam int unsigned CHAIN_W = STAGES * WIDTH;
      logic [CHAIN_W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
      end
      assign q = chain[CHAIN_W-1 -: WIDTH];
    end
  endgenerate

endmodule

// File: rtl/hpb_strobe.sv
module hpb_strobe
  import hpb_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              rw_s,
  input  logic              sel_s,
  input  logic [BYTE_W-1:0] data_s,
  output logic              wr_pulse,
  output logic              wr_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              drv_active,
  output logic              drv_sel,
  output logic              drv_end,
  output logic              err_set,
  output logic              err_clr
);

  localparam int unsigned CNT_W = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW_CYC);

  cyc_state_t        state, state_nx;
  logic [CNT_W-1:0]  low_cnt;
  logic              sel_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              drv_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:       if (!cs_n_s) state_nx = rw_s ? ST_DRIVE_CS : ST_WRITE;
      ST_WRITE: begin
        if (cs_n_s)    state_nx = ST_IDLE;
        else if (rw_s) state_nx = sel_q ? ST_FAULT : ST_DRIVE_RW;
      end
      ST_DRIVE_CS:   if (cs_n_s) state_nx = ST_IDLE;
      ST_PULSE_WAIT: begin
        if (cs_n_s)    state_nx = ST_IDLE;
        else if (rw_s) state_nx = ST_DRIVE_RW;
      end
      ST_DRIVE_RW: begin
        if (cs_n_s)     state_nx = ST_IDLE;
        else if (!rw_s) state_nx = ST_PULSE_WAIT;
      end
      ST_FAULT:      if (cs_n_s) state_nx = ST_IDLE;
      default:       state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      low_cnt <= '0;
      sel_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && !cs_n_s) begin
        sel_q   <= sel_s;
        low_cnt <= CNT_W'(1);
        wdata_q <= data_s;
      end else if (state == ST_WRITE && !cs_n_s) begin
        wdata_q <= data_s;
        if (low_cnt != CNT_MAX) low_cnt <= low_cnt + CNT_W'(1);
      end
    end
  end

  assign drv_active = (state == ST_DRIVE_CS) || (state == ST_DRIVE_RW);
  assign drv_nx     = (state_nx == ST_DRIVE_CS) || (state_nx == ST_DRIVE_RW);
  assign drv_end    = drv_active && !drv_nx;
  assign drv_sel    = sel_q;

  assign wr_pulse = (state == ST_WRITE) && cs_n_s && (low_cnt >= CNT_MAX);
  assign wr_sel   = sel_q;
  assign wr_data  = wdata_q;

  assign err_set = (state == ST_WRITE) && !cs_n_s && rw_s && sel_q;
  assign err_clr = (state == ST_IDLE) && !cs_n_s;

  AST_CAPTURE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(!cs_n_s)) else $error("capture without a preceding low strobe"); // R2

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(drv_active) && $past(cs_n_s)) |-> !drv_active) else $error("drive held after strobe end"); // R4

  AST_FAULT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_set) |-> !drv_active) else $error("drive during faulted window"); // R7

endmodule

// File: rtl/hpb_regs.sv
module hpb_regs
  import hpb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pulse,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              drv_active,
  input  logic              drv_sel,
  input  logic              drv_end,
  input  logic              err_set,
  input  logic              err_clr,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              pass_token,
  output logic              rx_valid,
  output logic              rx_sel,
  output logic [BYTE_W-1:0] rx_data,
  output logic [BYTE_W-1:0] drv_byte,
  output logic              token_at_slave,
  output logic              bus_error
);

  logic [BYTE_W-1:0] hold_q;
  logic              hold_full;
  logic              tok_q;
  logic              err_q;
  logic              give_tok;

  assign tx_ready = !hold_full && !(drv_active && !drv_sel);
  assign give_tok = wr_pulse && wr_sel && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end else if (tx_valid && tx_ready) begin
      hold_q    <= tx_data;
      hold_full <= 1'b1;
    end else if (drv_end && !drv_sel && hold_full) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tok_q <= 1'b0;
    else if (give_tok)   tok_q <= 1'b1;
    else if (pass_token) tok_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_sel   <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= wr_pulse;
      if (wr_pulse) begin
        rx_sel  <= wr_sel;
        rx_data <= wr_data;
      end
    end
  end

  assign drv_byte       = drv_sel ? status_byte(hold_full, tok_q) : (hold_full ? hold_q : '0);
  assign token_at_slave = tok_q;
  assign bus_error      = err_q;

  AST_TOKEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tok_q) |-> $past(pass_token)) else $error("token lost without pass"); // R8

  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_full) |-> $past(tx_valid)) else $error("holding filled without offer"); // R9

  AST_RX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid) else $error("receive strobe longer than one cycle"); // R10

endmodule

// File: rtl/hpb_port.sv
module hpb_port
  import hpb_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rw,
  input  logic              host_reg_sel,
  input  logic [BYTE_W-1:0] host_d_in,
  output logic [BYTE_W-1:0] host_d_out,
  output logic              host_d_oe,
  output logic              rx_valid,
  output logic              rx_sel,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              pass_token,
  output logic              token_at_slave,
  output logic              bus_error
);

  logic [2:0]        ctl_s;
  logic [BYTE_W-1:0] data_s;
  logic              wr_pulse, wr_sel, drv_active, drv_sel, drv_end, err_set, err_clr;
  logic [BYTE_W-1:0] wr_data;

  hpb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({host_cs_n, host_rw, host_reg_sel}), .q(ctl_s)
  );

  hpb_sync #(.WIDTH(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .d(host_d_in), .q(data_s)
  );

  hpb_strobe #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(ctl_s[2]), .rw_s(ctl_s[1]), .sel_s(ctl_s[0]), .data_s(data_s),
    .wr_pulse(wr_pulse), .wr_sel(wr_sel), .wr_data(wr_data),
    .drv_active(drv_active), .drv_sel(drv_sel), .drv_end(drv_end),
    .err_set(err_set), .err_clr(err_clr)
  );

  hpb_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_pulse(wr_pulse), .wr_sel(wr_sel), .wr_data(wr_data),
    .drv_active(drv_active), .drv_sel(drv_sel), .drv_end(drv_end),
    .err_set(err_set), .err_clr(err_clr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .pass_token(pass_token),
    .rx_valid(rx_valid), .rx_sel(rx_sel), .rx_data(rx_data),
    .drv_byte(host_d_out), .token_at_slave(token_at_slave), .bus_error(bus_error)
  );

  assign host_d_oe = drv_active;

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_error) |-> !host_d_oe) else $error("pad enabled on bus error"); // R7

endmodule

// File: tb/hpb_port_test.sv
module hpb_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_cs_n = 1'b1, host_rw = 1'b0, host_reg_sel = 1'b0;
  logic [7:0] host_d_in = 8'h00;
  logic [7:0] host_d_out, rx_data, tx_data = 8'h00;
  logic       host_d_oe, rx_valid, rx_sel, tx_ready, token_at_slave, bus_error;
  logic       tx_valid = 1'b0, pass_token = 1'b0;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hpb_port uut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rw(host_rw),
    .host_reg_sel(host_reg_sel), .host_d_in(host_d_in), .host_d_out(host_d_out),
    .host_d_oe(host_d_oe), .rx_valid(rx_valid), .rx_sel(rx_sel), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .pass_token(pass_token), .token_at_slave(token_at_slave), .bus_error(bus_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d, input int low_n,
                            output int pulses, output logic [7:0] got, output logic gsel);
    pulses = 0; got = 8'h00; gsel = 1'b0;
    host_reg_sel = sel; host_rw = 1'b0; host_d_in = d;
    @(negedge clk) host_cs_n = 1'b0;
    idle(low_n);
    host_cs_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (rx_valid) begin pulses++; got = rx_data; gsel = rx_sel; end
    end
  endtask

  task automatic host_read(input logic sel, output logic [7:0] got,
                           output int rise_lat, output int fall_lat);
    host_reg_sel = sel; host_rw = 1'b1;
    @(negedge clk) host_cs_n = 1'b0;
    rise_lat = 0;
    do begin @(negedge clk); rise_lat++; end while (!host_d_oe && rise_lat < 10);
    got = host_d_out;
    idle(2);
    host_cs_n = 1'b1;
    fall_lat = 0;
    do begin @(negedge clk); fall_lat++; end while (host_d_oe && fall_lat < 10);
    host_rw = 1'b0;
    idle(2);
  endtask

  task automatic load_tx(input logic [7:0] d);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk) tx_valid = 1'b0;
  endtask

  task automatic t_reset;
    check(host_d_oe == 1'b0, "R1 oe", host_d_oe, 0);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    check(token_at_slave == 1'b0, "R1 token", token_at_slave, 0);
    check(bus_error == 1'b0, "R1 bus_error", bus_error, 0);
    check(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
  endtask

  task automatic t_writes;
    int p; logic [7:0] g; logic s;
    host_write(1'b0, 8'hA5, 8, p, g, s);
    check(p == 1, "R2 pulse count", p, 1);
    check(g == 8'hA5, "R2 data", g, 8'hA5);
    check(s == 1'b0, "R2 sel", s, 0);
    host_write(1'b1, 8'h00, 8, p, g, s);
    check(p == 1 && s == 1'b1, "R10 control write on stream", {p[7:0], 7'b0, s}, 16'h0101);
    check(token_at_slave == 1'b0, "R8 bit0 clear keeps token", token_at_slave, 0);
    host_write(1'b0, 8'h3C, 4, p, g, s);
    check(p == 0, "R3 short strobe dropped", p, 0);
    host_write(1'b1, 8'h01, 4, p, g, s);
    check(p == 0 && token_at_slave == 1'b0, "R3 short control write ignored", {p[7:0], 7'b0, token_at_slave}, 0);
    host_write(1'b0, 8'hC3, 5, p, g, s);
    check(p == 1 && g == 8'hC3, "R2 minimum strobe accepted", g, 8'hC3);
  endtask

  task automatic t_reads;
    logic [7:0] g; int rl, fl;
    load_tx(8'h5A);
    check(tx_ready == 1'b0, "R9 full blocks ready", tx_ready, 0);
    host_read(1'b0, g, rl, fl);
    check(g == 8'h5A, "R4 data driven", g, 8'h5A);
    check(rl >= 1 && rl <= 6, "R4 drive latency", rl, 6);
    check(fl >= 1 && fl <= 6, "R4 release latency", fl, 6);
    check(tx_ready == 1'b1, "R9 drive empties holding", tx_ready, 1);
    host_read(1'b0, g, rl, fl);
    check(g == 8'h00, "R9 empty drive gives zero", g, 0);
    load_tx(8'h11);
    host_read(1'b1, g, rl, fl);
    check(g == 8'h02, "R5 status byte", g, 8'h02);
    check(rl <= 6 && fl <= 6, "R5 same timing", rl, 6);
    check(tx_ready == 1'b0, "R5 control read consumes nothing", tx_ready, 0);
  endtask

  task automatic t_token;
    int p; logic [7:0] g; logic s; int rl, fl;
    host_write(1'b1, 8'h01, 8, p, g, s);
    check(token_at_slave == 1'b1, "R8 token given", token_at_slave, 1);
    host_read(1'b1, g, rl, fl);
    check(g == 8'h03, "R5 status with token", g, 8'h03);
  endtask

  task automatic t_pulse;
    int lat; int p;
    host_reg_sel = 1'b0; host_rw = 1'b0;
    @(negedge clk) host_cs_n = 1'b0;
    idle(8);
    check(host_d_oe == 1'b0, "R6 no drive before pulse", host_d_oe, 0);
    host_rw = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!host_d_oe && lat < 10);
    check(lat <= 6, "R6 pulse drive latency", lat, 6);
    check(host_d_out == 8'h11, "R6 pulse drives holding byte", host_d_out, 8'h11);
    host_rw = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (host_d_oe && lat < 10);
    check(lat <= 6, "R6 pulse release latency", lat, 6);
    check(tx_ready == 1'b1, "R9 pulse drive consumed byte", tx_ready, 1);
    idle(2);
    host_rw = 1'b1;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!host_d_oe && lat < 10);
    check(host_d_oe == 1'b1 && host_d_out == 8'h00, "R6 second pulse empty byte", host_d_out, 0);
    check(tx_ready == 1'b0, "R9 ready low during data drive", tx_ready, 0);
    host_rw = 1'b0;
    idle(6);
    host_cs_n = 1'b1;
    p = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (rx_valid) p++; end
    check(p == 0, "R6 no capture in pulse window", p, 0);
    check(tx_ready == 1'b1, "R9 ready back after drive", tx_ready, 1);
  endtask

  task automatic t_fault;
    int p; bit saw_oe; logic [7:0] g; int rl, fl;
    host_reg_sel = 1'b1; host_rw = 1'b0; host_d_in = 8'h00;
    @(negedge clk) host_cs_n = 1'b0;
    idle(6);
    host_rw = 1'b1;
    saw_oe = 1'b0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (host_d_oe) saw_oe = 1'b1; end
    check(bus_error == 1'b1, "R7 error flagged", bus_error, 1);
    check(saw_oe == 1'b0, "R7 no drive", saw_oe, 0);
    host_cs_n = 1'b1;
    p = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (rx_valid) p++; end
    host_rw = 1'b0;
    check(p == 0, "R7 no byte received", p, 0);
    host_read(1'b1, g, rl, fl);
    check(bus_error == 1'b0, "R7 cleared by next cycle", bus_error, 0);
  endtask

  task automatic t_pass_and_clash;
    bit rx_seen;
    @(negedge clk) pass_token = 1'b1;
    @(negedge clk) pass_token = 1'b0;
    check(token_at_slave == 1'b0, "R8 pass returns token", token_at_slave, 0);
    @(negedge clk) pass_token = 1'b1;
    @(negedge clk) pass_token = 1'b0;
    check(token_at_slave == 1'b0, "R8 pass without token", token_at_slave, 0);
    begin
      int p; logic [7:0] g; logic s;
      host_write(1'b1, 8'h01, 8, p, g, s);
    end
    check(token_at_slave == 1'b1, "R8 token regiven", token_at_slave, 1);
    host_reg_sel = 1'b1; host_rw = 1'b0; host_d_in = 8'h01;
    @(negedge clk) host_cs_n = 1'b0;
    idle(8);
    host_cs_n = 1'b1;
    idle(2);
    pass_token = 1'b1;
    @(negedge clk) pass_token = 1'b0;
    rx_seen = rx_valid;
    check(rx_seen == 1'b1, "R8 write lands with pass", rx_seen, 1);
    check(token_at_slave == 1'b1, "R8 give wins over pass", token_at_slave, 1);
    idle(4);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_writes();
    t_reads();
    t_token();
    t_pulse();
    t_fault();
    t_pass_and_clash();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule